// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block passes single command or control words between two ports that run on unrelated clocks, without going through a queue. Port A deposits a word in the outbound register (Mail1), which Port B picks up. Port B deposits a word in the return register (Mail2), which Port A picks up. Each register has an active-low full flag, shown in the writer's clock domain. The flag drops when a word is accepted. It rises again only after the reader has taken the word, and until then further writes are refused.

Each port has a mailbox select. When the select is high, the port's read data comes from the incoming mailbox. When it is low, the read data comes from a FIFO output word supplied from outside. A static bus-size setting narrows the usable width of both mailboxes and of the read data to 36, 18 or 9 bits. Each port has its own asynchronous reset, and each reset is released synchronously inside the block.

Top module: `xmb_mailbox_pair`

## Requirements
- R1: A mailbox write is accepted on the rising edge of the writer's clock when that port's select, write-direction (1 = write), enable and mailbox-select inputs are all high and its full flag is high. Port A writes Mail1 and Port B writes Mail2.
- R2: In the writer's clock cycle after an accepted write, that mailbox's full flag is low.
- R3: While a full flag is low, every write to that mailbox is ignored and the stored word stays unchanged.
- R4: A reader read is select, enable and mailbox-select high with write-direction low, on the reader's clock, once the word has reached the reader's domain. After such a read, the writer's full flag returns high within six writer clock cycles.
- R5: Reading a mailbox leaves its stored word unchanged.
- R6: A port's read data shows the incoming mailbox word when its mailbox select is high, and the external FIFO word when the select is low.
- R7: The bus-size input codes are 2'b00 = 36 bits, 2'b01 = 18 bits (bits 17:0), 2'b10 = 9 bits (bits 8:0) and 2'b11 = 36 bits. Write-data bits above the selected width are ignored, and read-data bits above it are driven to zero.
- R8: After reset both full flags are high and both mailbox words are zero.
- R9: A write with the mailbox select low, or with the enable low, neither changes the mailbox nor lowers its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous active-low reset |
| a_sel | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A transfer enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_fifo_word | input | 36 | External FIFO word for Port A read data |
| a_rdata | output | 36 | Port A read data |
| a_m1_full_n | output | 1 | Mail1 full flag, active low, in the Port A domain |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous active-low reset |
| b_sel | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B transfer enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write data |
| b_fifo_word | input | 36 | External FIFO word for Port B read data |
| b_rdata | output | 36 | Port B read data |
| b_m2_full_n | output | 1 | Mail2 full flag, active low, in the Port B domain |
| bus_size | input | 2 | Static bus-size code |

## Verification
Six data words go round trip in both directions, one for each bus-size code, including the alias code 2'b11. The words have ones above the narrow widths, so masking on write and zeroing on read are told apart from a plain pass-through. Back-to-back writes show that a second word is refused while the flag is low. Peeks at the read data before and after a read show whether a read disturbs the stored word. Writes with the mailbox select low or the enable low show that only a fully qualified write sets the flag. A FIFO word with set high bits, read at two bus sizes, shows the mux choice together with the width zeroing.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {
    XMB_BUS_WIDE  = 2'b00,
    XMB_BUS_HALF  = 2'b01,
    XMB_BUS_BYTE  = 2'b10,
    XMB_BUS_WIDE2 = 2'b11
  } xmb_bus_e;
endpackage

// File: rtl/xmb_rst_sync.sv
module xmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xmb_channel.sv
module xmb_channel #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              w_put,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_full_n,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              r_take,
  output logic [DATA_W-1:0] r_word
);
  logic              w_tgl_q, w_tgl_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              r_tgl_q, r_tgl_d;
  logic              r_tgl_in_w;
  logic              w_tgl_in_r;
  logic              w_accept;
  logic              r_avail;
  logic              r_accept;

  // Writer domain: the flag is set while the two toggles disagree
  xmb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rd_to_wr (
    .clk(wclk), .rst_n(wrst_n), .d(r_tgl_q), .q(r_tgl_in_w)
  );

  always_comb begin
    w_full_n = (w_tgl_q == r_tgl_in_w);
    w_accept = w_put & w_full_n;
    w_tgl_d  = w_tgl_q ^ w_accept;
    word_d   = w_accept ? w_data : word_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      w_tgl_q <= 1'b0;
      word_q  <= '0;
    end else begin
      w_tgl_q <= w_tgl_d;
      if (w_accept) word_q <= word_d;
    end
  end

  // Reader domain: a take only counts once the word is visible here
  xmb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_wr_to_rd (
    .clk(rclk), .rst_n(rrst_n), .d(w_tgl_q), .q(w_tgl_in_r)
  );

  always_comb begin
    r_avail  = (w_tgl_in_r != r_tgl_q);
    r_accept = r_take & r_avail;
    r_tgl_d  = r_tgl_q ^ r_accept;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) r_tgl_q <= 1'b0;
    else         r_tgl_q <= r_tgl_d;
  end

  assign r_word = word_q;
endmodule

// File: rtl/xmb_mailbox_pair.sv
module xmb_mailbox_pair
  import xmb_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int HALF_W      = 18,
  parameter int BYTE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic              a_en,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [DATA_W-1:0] a_fifo_word,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_m1_full_n,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic              b_en,
  input  logic              b_mbx,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] b_fifo_word,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_m2_full_n,
  input  logic [1:0]        bus_size
);
  logic              a_rst_q, b_rst_q;
  logic [DATA_W-1:0] lane_mask;
  logic              a_put, a_take, b_put, b_take;
  logic [DATA_W-1:0] mail1_word, mail2_word;
  xmb_bus_e          size_e;

  xmb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
    .clk(a_clk), .arst_n(a_rst_n), .rst_n(a_rst_q)
  );
  xmb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
    .clk(b_clk), .arst_n(b_rst_n), .rst_n(b_rst_q)
  );

  // Static lane mask from the bus-size code
  always_comb begin
    size_e    = xmb_bus_e'(bus_size);
    lane_mask = '0;
    case (size_e)
      XMB_BUS_HALF: lane_mask[HALF_W-1:0] = '1;
      XMB_BUS_BYTE: lane_mask[BYTE_W-1:0] = '1;
      default:      lane_mask             = '1;
    endcase
  end

  // Port command decode
  always_comb begin
    a_put  = a_sel &  a_wr & a_en & a_mbx;
    a_take = a_sel & ~a_wr & a_en & a_mbx;
    b_put  = b_sel &  b_wr & b_en & b_mbx;
    b_take = b_sel & ~b_wr & b_en & b_mbx;
  end

  xmb_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
    .wclk(a_clk), .wrst_n(a_rst_q), .w_put(a_put),
    .w_data(a_wdata & lane_mask), .w_full_n(a_m1_full_n),
    .rclk(b_clk), .rrst_n(b_rst_q), .r_take(b_take), .r_word(mail1_word)
  );

  xmb_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
    .wclk(b_clk), .wrst_n(b_rst_q), .w_put(b_put),
    .w_data(b_wdata & lane_mask), .w_full_n(b_m2_full_n),
    .rclk(a_clk), .rrst_n(a_rst_q), .r_take(a_take), .r_word(mail2_word)
  );

  // Read data selection, upper lanes forced to zero
  always_comb begin
    a_rdata = (a_mbx ? mail2_word : a_fifo_word) & lane_mask;
    b_rdata = (b_mbx ? mail1_word : b_fifo_word) & lane_mask;
  end
endmodule

// File: rtl/xmb_mailbox_checks.sv
module xmb_mailbox_checks #(
  parameter int DATA_W = 36
) (
  input logic              a_clk,
  input logic              b_clk,
  input logic              a_rst_q,
  input logic              b_rst_q,
  input logic              a_sel,
  input logic              a_wr,
  input logic              a_en,
  input logic              a_mbx,
  input logic              b_sel,
  input logic              b_wr,
  input logic              b_en,
  input logic              b_mbx,
  input logic              a_m1_full_n,
  input logic              b_m2_full_n,
  input logic [DATA_W-1:0] mail1_word,
  input logic [DATA_W-1:0] mail2_word,
  input logic [DATA_W-1:0] a_rdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic [1:0]        bus_size
);
  AST_M1_FLAG_DROP: assert property (@(posedge a_clk) disable iff (!a_rst_q)
    (a_sel && a_wr && a_en && a_mbx && a_m1_full_n) |=> !a_m1_full_n); // R2
  AST_M2_FLAG_DROP: assert property (@(posedge b_clk) disable iff (!b_rst_q)
    (b_sel && b_wr && b_en && b_mbx && b_m2_full_n) |=> !b_m2_full_n); // R2
  AST_M1_HOLD_FULL: assert property (@(posedge a_clk) disable iff (!a_rst_q)
    !a_m1_full_n |=> $stable(mail1_word)); // R3
  AST_M2_HOLD_FULL: assert property (@(posedge b_clk) disable iff (!b_rst_q)
    !b_m2_full_n |=> $stable(mail2_word)); // R3
  AST_M1_NO_PUT_NO_DROP: assert property (@(posedge a_clk) disable iff (!a_rst_q)
    (a_m1_full_n && !(a_sel && a_wr && a_en && a_mbx)) |=> $stable(mail1_word)); // R9
  AST_B_BYTE_UPPER_ZERO: assert property (@(posedge b_clk) disable iff (!b_rst_q)
    (bus_size == 2'b10) |-> (b_rdata[DATA_W-1:9] == '0)); // R7
  AST_A_HALF_UPPER_ZERO: assert property (@(posedge a_clk) disable iff (!a_rst_q)
    (bus_size == 2'b01) |-> (a_rdata[DATA_W-1:18] == '0)); // R7
endmodule

bind xmb_mailbox_pair xmb_mailbox_checks #(.DATA_W(DATA_W)) u_checks (
  .a_clk(a_clk), .b_clk(b_clk), .a_rst_q(a_rst_q), .b_rst_q(b_rst_q),
  .a_sel(a_sel), .a_wr(a_wr), .a_en(a_en), .a_mbx(a_mbx),
  .b_sel(b_sel), .b_wr(b_wr), .b_en(b_en), .b_mbx(b_mbx),
  .a_m1_full_n(a_m1_full_n), .b_m2_full_n(b_m2_full_n),
  .mail1_word(mail1_word), .mail2_word(mail2_word),
  .a_rdata(a_rdata), .b_rdata(b_rdata), .bus_size(bus_size)
);

// File: tb/xmb_mailbox_pair_test.sv
module xmb_mailbox_pair_test;
  logic        a_clk = 1'b0, b_clk = 1'b0;
  logic        a_rst_n, b_rst_n;
  logic        a_sel, a_wr, a_en, a_mbx;
  logic        b_sel, b_wr, b_en, b_mbx;
  logic [35:0] a_wdata, a_fifo_word, a_rdata;
  logic [35:0] b_wdata, b_fifo_word, b_rdata;
  logic        a_m1_full_n, b_m2_full_n;
  logic [1:0]  bus_size;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 a_clk = ~a_clk;   // 200 MHz
  always #3.5 b_clk = ~b_clk;   // unrelated second clock

  xmb_mailbox_pair uut (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_sel(a_sel), .a_wr(a_wr), .a_en(a_en),
    .a_mbx(a_mbx), .a_wdata(a_wdata), .a_fifo_word(a_fifo_word),
    .a_rdata(a_rdata), .a_m1_full_n(a_m1_full_n),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_sel(b_sel), .b_wr(b_wr), .b_en(b_en),
    .b_mbx(b_mbx), .b_wdata(b_wdata), .b_fifo_word(b_fifo_word),
    .b_rdata(b_rdata), .b_m2_full_n(b_m2_full_n), .bus_size(bus_size)
  );

  // {bus_size, write word, expected read word}
  localparam logic [73:0] VEC [6] = '{
    {2'b00, 36'h9_ABCD_1234, 36'h9_ABCD_1234},
    {2'b01, 36'hF_FFFF_FFFF, 36'h0_0003_FFFF},
    {2'b10, 36'hF_0000_0155, 36'h0_0000_0155},
    {2'b11, 36'h5_5555_5555, 36'h5_5555_5555},
    {2'b01, 36'hA_BCDE_F012, 36'h0_0002_F012},
    {2'b10, 36'h0_0000_03FF, 36'h0_0000_01FF}
  };

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic a_wait(input int n); repeat (n) @(negedge a_clk); endtask
  task automatic b_wait(input int n); repeat (n) @(negedge b_clk); endtask

  task automatic a_write(input logic [35:0] d, input logic mbx, input logic en);
    @(negedge a_clk);
    a_sel = 1'b1; a_wr = 1'b1; a_en = en; a_mbx = mbx; a_wdata = d;
    @(negedge a_clk);
    a_sel = 1'b0; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b1;
  endtask

  task automatic b_write(input logic [35:0] d);
    @(negedge b_clk);
    b_sel = 1'b1; b_wr = 1'b1; b_en = 1'b1; b_mbx = 1'b1; b_wdata = d;
    @(negedge b_clk);
    b_sel = 1'b0; b_wr = 1'b0; b_en = 1'b0;
  endtask

  task automatic a_read(output logic [35:0] got);
    @(negedge a_clk);
    a_sel = 1'b1; a_wr = 1'b0; a_en = 1'b1; a_mbx = 1'b1;
    #1 got = a_rdata;
    @(negedge a_clk);
    a_sel = 1'b0; a_en = 1'b0;
  endtask

  task automatic b_read(output logic [35:0] got);
    @(negedge b_clk);
    b_sel = 1'b1; b_wr = 1'b0; b_en = 1'b1; b_mbx = 1'b1;
    #1 got = b_rdata;
    @(negedge b_clk);
    b_sel = 1'b0; b_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [35:0] got;
    a_rst_n = 1'b0; b_rst_n = 1'b0;
    a_sel = 0; a_wr = 0; a_en = 0; a_mbx = 1; a_wdata = '0; a_fifo_word = '0;
    b_sel = 0; b_wr = 0; b_en = 0; b_mbx = 1; b_wdata = '0; b_fifo_word = '0;
    bus_size = 2'b00;
    a_wait(3); b_wait(3);
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    a_wait(4); b_wait(4);

    // R8: reset state
    check("R8 mail1 flag", {35'b0, a_m1_full_n}, 36'd1);
    check("R8 mail2 flag", {35'b0, b_m2_full_n}, 36'd1);
    check("R8 mail1 word", b_rdata, 36'h0);
    check("R8 mail2 word", a_rdata, 36'h0);

    // Vector table: round trips in both directions at every bus size
    for (int i = 0; i < 6; i++) begin
      bus_size = VEC[i][73:72];
      a_write(VEC[i][71:36], 1'b1, 1'b1);
      check("R2 mail1 flag low", {35'b0, a_m1_full_n}, 36'd0);
      b_wait(6);
      b_read(got);
      check("R7 mail1 width", got, VEC[i][35:0]);
      a_wait(6);
      check("R4 mail1 flag released", {35'b0, a_m1_full_n}, 36'd1);
      b_write(VEC[i][71:36]);
      check("R2 mail2 flag low", {35'b0, b_m2_full_n}, 36'd0);
      a_wait(6);
      a_read(got);
      check("R1 mail2 word", got, VEC[i][35:0]);
      b_wait(6);
      check("R4 mail2 flag released", {35'b0, b_m2_full_n}, 36'd1);
    end

    // R3: a second write while full is refused
    bus_size = 2'b00;
    a_write(36'h1_1111_2222, 1'b1, 1'b1);
    a_write(36'h3_3333_4444, 1'b1, 1'b1);
    check("R3 flag still low", {35'b0, a_m1_full_n}, 36'd0);
    b_wait(6);
    #1 check("R3 first word kept", b_rdata, 36'h1_1111_2222);
    b_read(got);
    check("R1 mail1 read", got, 36'h1_1111_2222);
    b_wait(2);
    #1 check("R5 word intact after read", b_rdata, 36'h1_1111_2222);
    a_wait(6);
    check("R4 flag high after read", {35'b0, a_m1_full_n}, 36'd1);

    // R9: unqualified writes leave mailbox and flag alone
    a_write(36'h7_7777_7777, 1'b0, 1'b1);
    check("R9 mbx low flag", {35'b0, a_m1_full_n}, 36'd1);
    a_write(36'h8_8888_8888, 1'b1, 1'b0);
    check("R9 en low flag", {35'b0, a_m1_full_n}, 36'd1);
    b_wait(6);
    #1 check("R9 word untouched", b_rdata, 36'h1_1111_2222);

    // R6: FIFO word path
    @(negedge b_clk);
    b_mbx = 1'b0; b_fifo_word = 36'h1_2345_6789;
    #1 check("R6 fifo word wide", b_rdata, 36'h1_2345_6789);
    bus_size = 2'b10;
    #1 check("R6 fifo word byte", b_rdata, 36'h0_0000_0189);
    b_mbx = 1'b1;
    #1 check("R6 mailbox byte", b_rdata, 36'h0_0000_0022);
    @(negedge a_clk);
    a_mbx = 1'b0; a_fifo_word = 36'hF_0F0F_0F0F; bus_size = 2'b01;
    #1 check("R6 fifo word half", a_rdata, 36'h0_0003_0F0F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule